// File: doc/BRIEF.md
# Vector Sum Reduction Engine

This block sits beside an in-order core as a coprocessor. The core sends it an instruction word and two 64-bit source operands. Operand a is the base address of an array of 32-bit integers, and operand b is the element count. For the sum operation the engine streams one load per element to a shared data-memory port. It keeps many tagged loads in flight against a memory that takes several cycles to answer. It adds each returned element, sign-extended, into a 64-bit accumulator. When it has collected the last element, it writes the total back to the core's destination register through a response channel.

All four channels use a ready/valid handshake: command in, register writeback out, memory request out and memory response in. No ready is derived from a valid, and no valid from a ready; every one of them comes from state registers. A busy output tells the core that loads are still outstanding, so the core can fence or stall. An error output flags an instruction the engine does not implement.

The element index, taken modulo the tag space, is the load tag. The number of loads in flight is capped at the number of distinct tags, so no live tag is ever reused.

Top module: `vred_engine`

## Requirements
- R1: Out of reset and whenever no command is active, cmdReady is 1 and busy, error, memReqValid, memRespReady and rspValid are 0.
- R2: An accepted command with funct (instruction bits 31:25) equal to 1 and count N (low CNT_W bits of operand b) issues exactly N loads, in index order. Load i has address a + 4*i, tag i mod 2^TAG_W, command code 0 (load), size code 2 (four bytes) and zero write data.
- R3: While memReqReady stays high and the in-flight window is not full, loads go out on consecutive cycles without waiting for any response.
- R4: The number of loads issued but not yet answered never exceeds 2^TAG_W.
- R5: The returned value is the 64-bit wrapping sum of bits 31:0 of every load response, each sign-extended from bit 31.
- R6: The result is offered only after all N load responses have been accepted, with rspReg equal to instruction bits 11:7. It is offered only when instruction bit 14 is 1; with that bit 0 the engine returns to idle without offering a response.
- R7: A count of zero issues no memory request and, with bit 14 set, returns the value 0.
- R8: busy is 1 from the cycle after a valid command is accepted until the result has been taken (or, without a response, until the last load answer), and it is 1 in every cycle in which a load is outstanding.
- R9: A command whose funct is not 1 sets error from the next cycle, issues no memory request and no response, and leaves cmdReady at 1. error clears when the next command is accepted.
- R10: Once raised, memReqValid and rspValid stay high, with address, tag and result unchanged, until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine can take a command |
| cmdInst | input | 32 | Instruction word (funct, rs2, rs1, xd, xs1, xs2, rd, opcode) |
| cmdOpA | input | ADDR_W | Vector base address |
| cmdOpB | input | DATA_W | Element count (low CNT_W bits used) |
| rspValid | output | 1 | Result offered |
| rspReady | input | 1 | Core takes the result |
| rspReg | output | 5 | Destination register index |
| rspData | output | DATA_W | Reduction result |
| memReqValid | output | 1 | Load request offered |
| memReqReady | input | 1 | Memory takes the request |
| memReqCmd | output | 2 | Memory command code (0 = load) |
| memReqSize | output | 2 | Access size code (2 = four bytes) |
| memReqTag | output | TAG_W | Request tag |
| memReqAddr | output | ADDR_W | Byte address |
| memReqData | output | DATA_W | Write data (always zero) |
| memRespValid | input | 1 | Memory response offered |
| memRespReady | output | 1 | Engine takes the response |
| memRespCmd | input | 2 | Command code of the answered access |
| memRespTag | input | TAG_W | Tag of the answered access |
| memRespSize | input | 2 | Size code of the answered access |
| memRespData | input | DATA_W | Loaded data, element in bits 31:0 |
| busy | output | 1 | Command in progress |
| error | output | 1 | Last accepted command was unsupported |

## Verification
The bench builds the engine with TAG_W = 3 and CNT_W = 16. The in-flight window is then only eight loads, so a twenty-element sum with a ten-cycle memory fills the window, stalls issue and wraps the tag space several times within a short run. The narrow count field keeps the counters small without changing any behaviour. At this width the default latency still lets a six-element vector go out back to back. A throttled request-ready pattern and a stalled result handshake exercise the hold rules.

// File: rtl/vred_pkg.sv
package vred_pkg;

  localparam int ELEM_W = 32;
  localparam logic [6:0] FUNCT_SUM = 7'd1;
  localparam logic [1:0] MEM_LOAD = 2'd0;
  localparam logic [1:0] SIZE_CODE = 2'($clog2(ELEM_W / 8));

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RESP = 2'd2
  } vredState_e;

  typedef struct packed {
    logic [6:0] funct;
    logic [4:0] rs2;
    logic [4:0] rs1;
    logic       xd;
    logic       xs1;
    logic       xs2;
    logic [4:0] rd;
    logic [6:0] opcode;
  } vredInst_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic issue;
    logic accum;
  } vredStrobe_t;

endpackage

// File: rtl/vred_dp.sv
module vred_dp
  import vred_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32,
  parameter int TAG_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  vredStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [4:0]        cmdRd,
  input  logic              cmdXd,
  input  logic [ELEM_W-1:0] respElem,
  input  logic [TAG_W-1:0]  respTag,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [TAG_W-1:0]  memReqTag,
  output logic [4:0]        rspReg,
  output logic [DATA_W-1:0] rspData,
  output logic              xdFlag,
  output logic              cmdCntZero,
  output logic              moreToIssue,
  output logic              windowFull,
  output logic              lastResp
);

  localparam int WINDOW = 1 << TAG_W;
  localparam int SHIFT = $clog2(ELEM_W / 8);

  logic [ADDR_W-1:0] baseQ;
  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  issueIdx;
  logic [CNT_W-1:0]  recvCnt;
  logic [DATA_W-1:0] accQ;
  logic [4:0]        rdQ;
  logic              xdQ;
  logic [CNT_W-1:0]  outstanding;
  logic [DATA_W-1:0] elemExt;

  assign outstanding = issueIdx - recvCnt;
  assign elemExt = {{(DATA_W - ELEM_W){respElem[ELEM_W-1]}}, respElem};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ    <= '0;
      countQ   <= '0;
      issueIdx <= '0;
      recvCnt  <= '0;
      accQ     <= '0;
      rdQ      <= '0;
      xdQ      <= 1'b0;
    end else if (strobe.capture) begin
      baseQ    <= cmdBase;
      countQ   <= cmdCount;
      issueIdx <= '0;
      recvCnt  <= '0;
      accQ     <= '0;
      rdQ      <= cmdRd;
      xdQ      <= cmdXd;
    end else begin
      if (strobe.issue) issueIdx <= issueIdx + 1'b1;
      if (strobe.accum) begin
        recvCnt <= recvCnt + 1'b1;
        accQ    <= accQ + elemExt;
      end
    end
  end

  assign memReqAddr  = baseQ + (ADDR_W'(issueIdx) << SHIFT);
  assign memReqTag   = issueIdx[TAG_W-1:0];
  assign rspReg      = rdQ;
  assign rspData     = accQ;
  assign xdFlag      = xdQ;
  assign cmdCntZero  = (cmdCount == '0);
  assign moreToIssue = (issueIdx != countQ);
  assign windowFull  = (outstanding >= CNT_W'(WINDOW));
  assign lastResp    = (recvCnt + 1'b1 == countQ);

  // R4: in-flight loads bounded by tag space
  a_r4_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= CNT_W'(WINDOW));

  // R4: an answered tag belongs to a load still in flight
  logic [TAG_W-1:0] tagDist;
  assign tagDist = issueIdx[TAG_W-1:0] - respTag;
  a_r4_resp_tag_live: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accum && !windowFull) |-> (tagDist != '0) && (CNT_W'(tagDist) <= outstanding));

endmodule

// File: rtl/vred_ctrl.sv
module vred_ctrl
  import vred_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [6:0]  cmdFunct,
  input  logic        cmdXd,
  input  logic        cmdCntZero,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  logic [1:0]  memRespCmd,
  input  logic        rspReady,
  input  logic        moreToIssue,
  input  logic        windowFull,
  input  logic        lastResp,
  input  logic        xdFlag,
  output vredStrobe_t strobe,
  output logic        cmdReady,
  output logic        memReqValid,
  output logic        memRespReady,
  output logic        rspValid,
  output logic        busy,
  output logic        error
);

  vredState_e stateQ, stateD;
  logic accept;
  logic goodCmd;

  assign cmdReady     = (stateQ == ST_IDLE);
  assign memRespReady = (stateQ == ST_RUN);
  assign rspValid     = (stateQ == ST_RESP);
  assign busy         = (stateQ != ST_IDLE);
  assign memReqValid  = (stateQ == ST_RUN) && moreToIssue && !windowFull;

  assign accept  = cmdValid && cmdReady;
  assign goodCmd = (cmdFunct == FUNCT_SUM);

  always_comb begin
    strobe.capture = accept && goodCmd;
    strobe.issue   = memReqValid && memReqReady;
    strobe.accum   = memRespValid && memRespReady && (memRespCmd == MEM_LOAD);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (strobe.capture) begin
          if (!cmdCntZero)  stateD = ST_RUN;
          else if (cmdXd)   stateD = ST_RESP;
        end
      end
      ST_RUN: begin
        if (strobe.accum && lastResp) stateD = xdFlag ? ST_RESP : ST_IDLE;
      end
      ST_RESP: begin
        if (rspReady) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      error  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (accept) error <= !goodCmd;
    end
  end

  // R9: a flagged command never leads to memory traffic
  a_r9_error_quiet: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !memReqValid);

  // R6: a result is only offered for commands that asked for one
  a_r6_rsp_needs_xd: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> xdFlag);

endmodule

// File: rtl/vred_engine.sv
module vred_engine
  import vred_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 32,
  parameter int TAG_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [31:0]       cmdInst,
  input  logic [ADDR_W-1:0] cmdOpA,
  input  logic [DATA_W-1:0] cmdOpB,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [4:0]        rspReg,
  output logic [DATA_W-1:0] rspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [1:0]        memReqCmd,
  output logic [1:0]        memReqSize,
  output logic [TAG_W-1:0]  memReqTag,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memRespValid,
  output logic              memRespReady,
  input  logic [1:0]        memRespCmd,
  input  logic [TAG_W-1:0]  memRespTag,
  input  logic [1:0]        memRespSize,
  input  logic [DATA_W-1:0] memRespData,
  output logic              busy,
  output logic              error
);

  vredInst_t   inst;
  vredStrobe_t strobe;
  logic        xdFlag;
  logic        cmdCntZero;
  logic        moreToIssue;
  logic        windowFull;
  logic        lastResp;
  logic        unusedBits;

  assign inst = vredInst_t'(cmdInst);
  assign unusedBits = ^{inst.rs1, inst.rs2, inst.xs1, inst.xs2, inst.opcode,
                        cmdOpB[DATA_W-1:CNT_W], memRespData[DATA_W-1:ELEM_W], memRespSize};

  assign memReqCmd  = MEM_LOAD;
  assign memReqSize = SIZE_CODE;
  assign memReqData = '0;

  vred_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdFunct     (inst.funct),
    .cmdXd        (inst.xd),
    .cmdCntZero   (cmdCntZero),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .memRespCmd   (memRespCmd),
    .rspReady     (rspReady),
    .moreToIssue  (moreToIssue),
    .windowFull   (windowFull),
    .lastResp     (lastResp),
    .xdFlag       (xdFlag),
    .strobe       (strobe),
    .cmdReady     (cmdReady),
    .memReqValid  (memReqValid),
    .memRespReady (memRespReady),
    .rspValid     (rspValid),
    .busy         (busy),
    .error        (error)
  );

  vred_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .TAG_W  (TAG_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdBase     (cmdOpA),
    .cmdCount    (cmdOpB[CNT_W-1:0]),
    .cmdRd       (inst.rd),
    .cmdXd       (inst.xd),
    .respElem    (memRespData[ELEM_W-1:0]),
    .respTag     (memRespTag),
    .memReqAddr  (memReqAddr),
    .memReqTag   (memReqTag),
    .rspReg      (rspReg),
    .rspData     (rspData),
    .xdFlag      (xdFlag),
    .cmdCntZero  (cmdCntZero),
    .moreToIssue (moreToIssue),
    .windowFull  (windowFull),
    .lastResp    (lastResp)
  );

  // R10: request held with stable payload until taken
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid && $stable(memReqAddr) && $stable(memReqTag));

  // R10: result held with stable payload until taken
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> rspValid && $stable(rspData) && $stable(rspReg));

  // R8: memory traffic only while busy
  a_r8_busy_pending: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || memRespReady) |-> busy);

endmodule

// File: tb/vred_engine_test.sv
`timescale 1ns/1ps
module vred_engine_test;

  localparam int TAG_W = 3;
  localparam int CNT_W = 16;
  localparam int WIN = 1 << TAG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [31:0] cmdInst = '0;
  logic [63:0] cmdOpA = '0;
  logic [63:0] cmdOpB = '0;
  logic rspReady = 1'b1;
  logic memReqReady = 1'b0;
  logic memRespValid = 1'b0;
  logic [1:0] memRespCmd = '0;
  logic [TAG_W-1:0] memRespTag = '0;
  logic [1:0] memRespSize = '0;
  logic [63:0] memRespData = '0;

  logic cmdReady, rspValid, memReqValid, memRespReady, busy, error;
  logic [4:0] rspReg;
  logic [63:0] rspData, memReqAddr, memReqData;
  logic [1:0] memReqCmd, memReqSize;
  logic [TAG_W-1:0] memReqTag;

  vred_engine #(.ADDR_W(64), .DATA_W(64), .CNT_W(CNT_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdInst(cmdInst), .cmdOpA(cmdOpA), .cmdOpB(cmdOpB),
    .rspValid(rspValid), .rspReady(rspReady), .rspReg(rspReg), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqCmd(memReqCmd),
    .memReqSize(memReqSize), .memReqTag(memReqTag), .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memRespValid(memRespValid), .memRespReady(memRespReady), .memRespCmd(memRespCmd),
    .memRespTag(memRespTag), .memRespSize(memRespSize), .memRespData(memRespData),
    .busy(busy), .error(error)
  );

  always #2.5 clk = ~clk;

  // counters: main flow and per-clock model keep separate ones
  int checks = 0, failures = 0;
  int blkChecks = 0, blkFails = 0;
  bit finished = 1'b0;

  // knobs written by the main flow only
  int lat = 4;
  int readyMode = 0;
  int rspStallReq = 0;

  // state written by the per-clock model only
  int cyc = 0;
  logic [63:0] reqAddrLog[$];
  logic [TAG_W-1:0] reqTagLog[$];
  int fireCyc[$];
  logic [63:0] pendAddr[$];
  logic [TAG_W-1:0] pendTag[$];
  int pendDue[$];
  int respCount = 0;
  int maxOut = 0;
  int rspCount = 0;
  logic [4:0] lastRspReg = '0;
  logic [63:0] lastRspData = '0;
  int rspLowRun = 0;
  int rspLowSeen = 0;

  function automatic logic [31:0] memWord(input logic [63:0] a);
    logic [31:0] x;
    x = a[31:0] ^ a[63:32];
    x = x * 32'h9E37_79B1;
    return x ^ (x >> 13);
  endfunction

  function automatic logic [63:0] expSum(input logic [63:0] base, input int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += longint'($signed(memWord(base + 64'(4 * i))));
    return 64'(s);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic blkCheck(input bit ok, input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    blkChecks++;
    if (!ok) begin
      blkFails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural memory and per-clock reference comparison
  always @(negedge clk) begin
    int outNow;
    memReqReady = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 2);
    if (rspValid && rspLowRun < rspStallReq) begin
      rspReady = 1'b0;
      rspLowRun++;
    end else begin
      rspReady = 1'b1;
    end
    if (pendDue.size() > 0 && pendDue[0] <= cyc) begin
      memRespValid = 1'b1;
      memRespCmd   = 2'd0;
      memRespSize  = 2'd2;
      memRespTag   = pendTag[0];
      memRespData  = {~memWord(pendAddr[0]), memWord(pendAddr[0])};
    end else begin
      memRespValid = 1'b0;
      memRespData  = '0;
    end
    #1;
    if (rstN) begin
      if (memReqValid && memReqReady) begin
        // R2: request format
        blkCheck(memReqCmd == 2'd0 && memReqSize == 2'd2 && memReqData == '0, "R2",
                 "request cmd/size/data", {memReqData[59:0], memReqCmd, memReqSize}, 64'h2);
        reqAddrLog.push_back(memReqAddr);
        reqTagLog.push_back(memReqTag);
        fireCyc.push_back(cyc);
        pendAddr.push_back(memReqAddr);
        pendTag.push_back(memReqTag);
        pendDue.push_back(cyc + lat);
      end
      if (memRespValid && memRespReady) begin
        void'(pendAddr.pop_front());
        void'(pendTag.pop_front());
        void'(pendDue.pop_front());
        respCount++;
      end
      outNow = reqAddrLog.size() - respCount;
      if (memReqValid && memReqReady)
        blkCheck(outNow <= WIN, "R4", "loads in flight", 64'(outNow), 64'(WIN));
      if (outNow > maxOut) maxOut = outNow;
      if (outNow > 0) blkCheck(busy, "R8", "busy while load outstanding", 64'(busy), 64'd1);
      if (rspValid && rspReady) begin
        rspCount++;
        lastRspReg  = rspReg;
        lastRspData = rspData;
        rspLowSeen  = rspLowRun;
        rspLowRun   = 0;
      end
    end
    cyc++;
  end

  int startReq = 0;
  int startRsp = 0;

  task automatic sendCmd(input logic [6:0] f, input logic [63:0] base, input int n,
                         input logic xd, input logic [4:0] rd);
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    startReq = reqAddrLog.size();
    startRsp = rspCount;
    cmdInst  = {f, 5'd7, 5'd6, xd, 1'b1, 1'b1, rd, 7'b0001011};
    cmdOpA   = base;
    cmdOpB   = 64'(n);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(n < 20000, req, "command completes", 64'(n), 64'd0);
  endtask

  task automatic checkLog(input logic [63:0] base, input int n, input string req);
    int bad = 0;
    check(reqAddrLog.size() - startReq == n, req, "load count",
          64'(reqAddrLog.size() - startReq), 64'(n));
    for (int i = 0; i < n && startReq + i < reqAddrLog.size(); i++) begin
      if (reqAddrLog[startReq + i] != base + 64'(4 * i) ||
          reqTagLog[startReq + i] != TAG_W'(i)) bad++;
    end
    check(bad == 0, req, "address/tag mismatches", 64'(bad), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check(cmdReady == 1'b1, "R1", "cmdReady", 64'(cmdReady), 64'd1);
    check({busy, error, memReqValid, memRespReady, rspValid} == 5'b0, "R1", "idle outputs",
          64'({busy, error, memReqValid, memRespReady, rspValid}), 64'd0);

    // R3/R2/R5/R6: short vector, ready held high, back-to-back issue
    lat = 4; readyMode = 0;
    sendCmd(7'd1, 64'h1000, 6, 1'b1, 5'd5);
    waitIdle("R8");
    checkLog(64'h1000, 6, "R2");
    begin
      int gaps = 0;
      for (int i = startReq + 1; i < fireCyc.size(); i++)
        if (fireCyc[i] != fireCyc[i-1] + 1) gaps++;
      check(gaps == 0, "R3", "gaps between loads", 64'(gaps), 64'd0);
    end
    check(rspCount - startRsp == 1, "R6", "one response", 64'(rspCount - startRsp), 64'd1);
    check(lastRspReg == 5'd5, "R6", "destination index", 64'(lastRspReg), 64'd5);
    check(lastRspData == expSum(64'h1000, 6), "R5", "sum of 6", lastRspData, expSum(64'h1000, 6));
    check(!busy && cmdReady, "R8", "busy drops after result", 64'(busy), 64'd0);

    // R4: long latency fills the window, tags wrap
    lat = 10;
    sendCmd(7'd1, 64'h2000_0004, 20, 1'b1, 5'd17);
    waitIdle("R8");
    checkLog(64'h2000_0004, 20, "R2");
    check(maxOut == WIN, "R4", "peak loads in flight", 64'(maxOut), 64'(WIN));
    check(lastRspData == expSum(64'h2000_0004, 20), "R5", "sum of 20",
          lastRspData, expSum(64'h2000_0004, 20));
    check(lastRspReg == 5'd17, "R6", "destination index", 64'(lastRspReg), 64'd17);

    // R2/R5: throttled request ready
    lat = 5; readyMode = 1;
    sendCmd(7'd1, 64'hFFFF_FFFF_FFFF_FF00, 13, 1'b1, 5'd3);
    waitIdle("R8");
    checkLog(64'hFFFF_FFFF_FFFF_FF00, 13, "R2");
    check(lastRspData == expSum(64'hFFFF_FFFF_FFFF_FF00, 13), "R5", "sum throttled",
          lastRspData, expSum(64'hFFFF_FFFF_FFFF_FF00, 13));
    readyMode = 0;

    // R7: zero count
    sendCmd(7'd1, 64'h3000, 0, 1'b1, 5'd9);
    waitIdle("R7");
    check(reqAddrLog.size() == startReq, "R7", "no loads", 64'(reqAddrLog.size() - startReq), 64'd0);
    check(rspCount - startRsp == 1 && lastRspData == 64'd0 && lastRspReg == 5'd9, "R7",
          "zero result", lastRspData, 64'd0);

    // R6: no writeback requested
    sendCmd(7'd1, 64'h4000, 4, 1'b0, 5'd12);
    waitIdle("R6");
    repeat (3) @(negedge clk);
    checkLog(64'h4000, 4, "R2");
    check(rspCount == startRsp, "R6", "no response without xd", 64'(rspCount - startRsp), 64'd0);
    check(!busy && cmdReady, "R6", "back to idle", 64'(busy), 64'd0);

    // R9: unsupported funct
    sendCmd(7'd3, 64'h5000, 5, 1'b1, 5'd4);
    repeat (4) @(negedge clk);
    check(error == 1'b1, "R9", "error raised", 64'(error), 64'd1);
    check(reqAddrLog.size() == startReq, "R9", "no loads", 64'(reqAddrLog.size() - startReq), 64'd0);
    check(rspCount == startRsp && cmdReady && !busy, "R9", "no response, idle",
          64'(rspCount - startRsp), 64'd0);

    // R10/R9: stalled result, error cleared by next command
    rspStallReq = 3; lat = 4;
    sendCmd(7'd1, 64'h6000, 3, 1'b1, 5'd30);
    check(error == 1'b0, "R9", "error cleared", 64'(error), 64'd0);
    waitIdle("R8");
    check(rspLowSeen == 3, "R10", "cycles result held", 64'(rspLowSeen), 64'd3);
    check(lastRspData == expSum(64'h6000, 3) && lastRspReg == 5'd30, "R10", "held result",
          lastRspData, expSum(64'h6000, 3));
    rspStallReq = 0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks + blkChecks, failures + blkFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run incomplete actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + blkChecks, failures + blkFails);
      $finish;
    end
  end

endmodule